// File: doc/BRIEF.md
# Masked Alarm Match Interrupt Unit

This unit raises a time-of-day alarm for a real-time clock. A separate timekeeper supplies the current seconds, minutes, hours and date in BCD, together with a one-cycle pulse each time those fields advance by one second. The unit holds four alarm bytes written over a small byte-wide host register port. Each alarm byte carries a compare value and a don't-care bit. On every second pulse, each field is compared with its alarm value. A field whose don't-care bit is set counts as matching whatever the time.

When all four fields match on a second pulse, a sticky event flag is set. The host reads the flag from a status register, and that read clears it. A level interrupt output follows the flag, but only while the host has set an enable bit in a control register. Setting every don't-care bit turns the unit into a once-per-second interrupt source. Keeping time and any watchdog function belong to other blocks.

Top module: `alm_match_irq`

## Requirements
- R1: The alarm bytes sit at offsets 0x8 (seconds), 0x9 (minutes), 0xA (hours) and 0xB (date). In each byte, bit 7 is the don't-care bit. The compare value is bits 6:0 for seconds and minutes and bits 5:0 for hours and date. A byte written there reads back with its unused bit 6 (hours, date) as 0.
- R2: A field matches when its don't-care bit is 1, or when its stored BCD value equals the current BCD value of that field.
- R3: The event flag is set only in a cycle where `sec_tick` is 1 and all four fields match. A mismatch on a tick, or a full match with no tick, leaves the flag unchanged.
- R4: With all four don't-care bits set, every `sec_tick` pulse sets the flag.
- R5: The flag is bit 0 of the status register at offset 0xE, and the other bits of that register read 0. A read of 0xE (`rd_en` with `addr` = 0xE) returns the flag's value before the read, and the flag is 0 from the next cycle on.
- R6: The interrupt enable is bit 3 of the control register at offset 0xF, and the other bits of that register read 0. `irq` is active high and equals flag AND enable. It stays high until the flag is cleared or the enable is written to 0.
- R7: If a status read and a flag-setting tick fall in the same cycle, the flag is 1 afterwards.
- R8: After a synchronous active-low reset, all alarm bytes, the enable and the flag are 0, and `irq` is 0.
- R9: Writes to offset 0xE and to unmapped offsets have no effect. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle pulse, time fields just updated |
| addr | input | ADDR_W (4) | Host register offset |
| wr_en | input | 1 | Host write strobe |
| wdata | input | DATA_W (8) | Host write data |
| rd_en | input | 1 | Host read strobe (clears the flag at 0xE) |
| rdata | output | DATA_W (8) | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, active high |

## Verification
A status read that clears the flag and a tick that sets it can fall in the same cycle. The bench provokes this in directed steps, both with the flag already set and with it clear. Random traffic also makes it happen, because it mixes reads of 0xE with ticks whose time fields are often copied from the stored alarm values. Each collision is judged in two ways. The read data must show the flag as it was before the cycle. The next read must show the flag set, and `irq` must be high whenever the enable is on.

// File: rtl/alm_pkg.sv
// Package: shared constants and helpers for the alarm match interrupt unit.
// Assumes BCD time fields no wider than FIELD_MAX_W bits.
package alm_pkg;

    localparam int ALM_FIELDS    = 4;
    localparam int FIELD_MAX_W   = 7;
    localparam int MASK_BIT      = 7;
    localparam int OFS_ALM_BASE  = 8;
    localparam int OFS_STAT      = 14;
    localparam int OFS_CTRL      = 15;
    localparam int STAT_FLAG_BIT = 0;
    localparam int CTRL_EN_BIT   = 3;

    typedef logic [FIELD_MAX_W-1:0] fld_t;

    // Width of the BCD compare value for field i (0 sec, 1 min, 2 hour, 3 date).
    function automatic int field_width(input int i);
        return (i < 2) ? 7 : 6;
    endfunction

endpackage

// File: rtl/alm_field_match.sv
// Module: one field comparator.
// A field matches when its don't-care bit is set or the values are equal.
// Assumes both operands are zero-extended to the same width.
module alm_field_match #(
    parameter int W = 7
) (
    input  logic [W-1:0] alarm_val,
    input  logic [W-1:0] cur_val,
    input  logic         dont_care,
    output logic         hit
);

    // Purpose: equality compare, overridden by the don't-care bit.
    always_comb begin
        hit = dont_care | (alarm_val == cur_val);
    end

endmodule

// File: rtl/alm_regfile.sv
// Module: host-visible registers of the alarm unit.
// It holds the four alarm bytes and the interrupt enable, and drives the read mux.
// Assumes a single-cycle write strobe; the status flag lives elsewhere and comes in.
module alm_regfile
    import alm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  flag,
    output fld_t [ALM_FIELDS-1:0] alarm_val,
    output logic [ALM_FIELDS-1:0] alarm_mask,
    output logic                  irq_en,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0] alm_byte [ALM_FIELDS];

    for (genvar i = 0; i < ALM_FIELDS; i++) begin : g_alarm
        localparam int W = field_width(i);
        logic [W-1:0] val_q;
        logic         msk_q;

        // Purpose: capture the value and don't-care bit of this alarm byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                msk_q <= 1'b0;
            end else if (wr_en && addr == ADDR_W'(OFS_ALM_BASE + i)) begin
                val_q <= wdata[W-1:0];
                msk_q <= wdata[MASK_BIT];
            end
        end

        assign alarm_val[i]  = fld_t'(val_q);
        assign alarm_mask[i] = msk_q;
        assign alm_byte[i]   = {msk_q, (DATA_W-1)'(val_q)};
    end

    // Purpose: hold the interrupt enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (wr_en && addr == ADDR_W'(OFS_CTRL)) begin
            irq_en <= wdata[CTRL_EN_BIT];
        end
    end

    // Purpose: select read data by offset; unmapped offsets give zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < ALM_FIELDS; i++) begin
            if (addr == ADDR_W'(OFS_ALM_BASE + i)) begin
                rdata = alm_byte[i];
            end
        end
        if (addr == ADDR_W'(OFS_STAT)) begin
            rdata[STAT_FLAG_BIT] = flag;
        end
        if (addr == ADDR_W'(OFS_CTRL)) begin
            rdata[CTRL_EN_BIT] = irq_en;
        end
    end

endmodule

// File: rtl/alm_event_flag.sv
// Module: sticky event flag and interrupt gate.
// Setting wins over clearing in the same cycle, so an event is never lost.
// Assumes set and clear are single-cycle qualified strobes.
module alm_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    // Purpose: sticky flag, set by a matching tick, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_evt) begin
            flag <= 1'b0;
        end
    end

    // Purpose: level interrupt, gated by the enable.
    always_comb begin
        irq = flag & irq_en;
    end

endmodule

// File: rtl/alm_match_irq.sv
// Module: top of the masked alarm match interrupt unit.
// It compares the BCD time with the alarm bytes on each second tick and raises a flag and interrupt.
// Assumes the time fields are already updated in the cycle that sec_tick is high.
module alm_match_irq
    import alm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [5:0]        cur_date,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    fld_t [ALM_FIELDS-1:0] alarm_val;
    fld_t [ALM_FIELDS-1:0] cur_pack;
    logic [ALM_FIELDS-1:0] alarm_mask;
    logic [ALM_FIELDS-1:0] field_hit;
    logic                  alarm_hit;
    logic                  irq_en;
    logic                  flag_q;
    logic                  stat_read;

    assign cur_pack[0] = fld_t'(cur_sec);
    assign cur_pack[1] = fld_t'(cur_min);
    assign cur_pack[2] = fld_t'(cur_hour);
    assign cur_pack[3] = fld_t'(cur_date);

    alm_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .flag       (flag_q),
        .alarm_val  (alarm_val),
        .alarm_mask (alarm_mask),
        .irq_en     (irq_en),
        .rdata      (rdata)
    );

    for (genvar i = 0; i < ALM_FIELDS; i++) begin : g_cmp
        alm_field_match #(
            .W (FIELD_MAX_W)
        ) u_cmp (
            .alarm_val (alarm_val[i]),
            .cur_val   (cur_pack[i]),
            .dont_care (alarm_mask[i]),
            .hit       (field_hit[i])
        );
    end

    // Purpose: all fields must agree for an alarm match.
    always_comb begin
        alarm_hit = &field_hit;
    end

    // Purpose: decode the flag-clearing status read.
    always_comb begin
        stat_read = rd_en && (addr == ADDR_W'(OFS_STAT));
    end

    alm_event_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (sec_tick & alarm_hit),
        .clr_evt (stat_read),
        .irq_en  (irq_en),
        .flag    (flag_q),
        .irq     (irq)
    );

endmodule

// File: rtl/alm_match_irq_chk.sv
// Checker: temporal properties of the alarm unit, bound to the top.
module alm_match_irq_chk
    import alm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic                  sec_tick,
    input logic                  irq,
    input logic                  flag,
    input logic                  irq_en,
    input logic [ALM_FIELDS-1:0] alarm_mask,
    input logic                  alarm_hit
);

    // R3: with no tick, a clear flag stays clear
    p_no_tick_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !flag) |=> !flag);

    // R4: all fields masked -> every tick sets the flag
    p_all_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (&alarm_mask)) |=> flag);

    // R5: a status read without a tick clears the flag
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_STAT) && !sec_tick) |=> !flag);

    // R7: a matching tick always leaves the flag set, even when a read collides
    p_collide_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && alarm_hit) |=> flag);

    // R6: irq holds until a status read or an enable write
    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd_en && addr == ADDR_W'(OFS_STAT))
             && !(wr_en && addr == ADDR_W'(OFS_CTRL))) |=> irq);

    // R6: irq never high while the enable is off
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

bind alm_match_irq alm_match_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .sec_tick   (sec_tick),
    .irq        (irq),
    .flag       (flag_q),
    .irq_en     (irq_en),
    .alarm_mask (alarm_mask),
    .alarm_hit  (alarm_hit)
);

// File: tb/alm_match_irq_test.sv
// Bench: directed corners plus seeded random traffic against a behavioural model.
module alm_match_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cur_sec = '0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [5:0] cur_date = '0;
    logic       sec_tick = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] alm_m [4];
    bit         en_m = 0;
    bit         flag_m = 0;

    always #2 clk = ~clk;

    alm_match_irq uut (
        .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_date(cur_date), .sec_tick(sec_tick),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .rdata(rdata), .irq(irq)
    );

    function automatic bit exp_hit(input logic [6:0] s, input logic [6:0] m,
                                   input logic [5:0] h, input logic [5:0] d);
        bit ok0, ok1, ok2, ok3;
        ok0 = alm_m[0][7] || (alm_m[0][6:0] == s);
        ok1 = alm_m[1][7] || (alm_m[1][6:0] == m);
        ok2 = alm_m[2][7] || (alm_m[2][5:0] == h);
        ok3 = alm_m[3][7] || (alm_m[3][5:0] == d);
        return ok0 && ok1 && ok2 && ok3;
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        case (a)
            4'h8, 4'h9, 4'hA, 4'hB: return alm_m[a - 4'h8];
            4'hE: return {7'b0, flag_m};
            4'hF: return {4'b0, en_m, 3'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check before the edge, update model after it.
    task automatic step(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d,
                        input bit t, input logic [6:0] s, input logic [6:0] m,
                        input logic [5:0] h, input logic [5:0] dt, input string tag);
        bit hit;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        sec_tick = t; cur_sec = s; cur_min = m; cur_hour = h; cur_date = dt;
        #1;
        if (r) check({tag, " rdata"}, rdata, exp_read(a));
        check({tag, " irq"}, {7'b0, irq}, {7'b0, flag_m & en_m});
        hit = exp_hit(s, m, h, dt);
        @(posedge clk);
        if (t && hit) flag_m = 1;
        else if (r && a == 4'hE) flag_m = 0;
        if (w && a >= 4'h8 && a <= 4'hB)
            alm_m[a - 4'h8] = d & ((a <= 4'h9) ? 8'hFF : 8'hBF);
        if (w && a == 4'hF) en_m = d[3];
        #0;
        wr_en = 0; rd_en = 0; sec_tick = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        step(1, 0, a, d, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(0, 1, a, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                        input logic [5:0] dt, input string tag);
        step(0, 0, 0, 0, 1, s, m, h, dt, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) alm_m[i] = 8'h00;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        check("R8 irq", {7'b0, irq}, 8'h00);
        for (int a = 8; a < 16; a++) rd(4'(a), "R8");

        // R1: readback with width masking
        wr(4'h8, 8'hFF, "R1"); rd(4'h8, "R1");
        wr(4'hA, 8'hFF, "R1"); rd(4'hA, "R1");
        wr(4'hB, 8'h71, "R1"); rd(4'hB, "R1");
        wr(4'h9, 8'h45, "R1"); rd(4'h9, "R1");

        // R9: writes to status and unmapped offsets have no effect
        wr(4'hE, 8'hFF, "R9"); rd(4'hE, "R9");
        wr(4'h3, 8'hAA, "R9"); rd(4'h3, "R9"); rd(4'hC, "R9");

        // R4: all masked fires every tick
        for (int i = 8; i < 12; i++) wr(4'(i), 8'h80, "R4");
        for (int k = 0; k < 3; k++) begin
            tick(7'(to_bcd(k)), 7'h10, 6'h05, 6'h12, "R4");
            rd(4'hE, "R4");
        end

        // R2/R3: exact match, mismatch, and match without tick
        wr(4'h8, 8'h30, "R2"); wr(4'h9, 8'h15, "R2");
        wr(4'hA, 8'h23, "R2"); wr(4'hB, 8'h31, "R2");
        tick(7'h30, 7'h15, 6'h23, 6'h30, "R3");
        rd(4'hE, "R3");
        step(0, 0, 0, 0, 0, 7'h30, 7'h15, 6'h23, 6'h31, "R3");
        rd(4'hE, "R3");
        tick(7'h30, 7'h15, 6'h23, 6'h31, "R2");
        rd(4'hE, "R2");
        wr(4'hA, 8'h80, "R2");
        tick(7'h30, 7'h15, 6'h07, 6'h31, "R2");
        rd(4'hE, "R2");

        // R6: enable gating and level hold
        tick(7'h30, 7'h15, 6'h07, 6'h31, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        wr(4'hF, 8'hFF, "R6"); rd(4'hF, "R6");
        repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        rd(4'hE, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");

        // R7: read and matching tick in the same cycle
        step(0, 1, 4'hE, 0, 1, 7'h30, 7'h15, 6'h01, 6'h31, "R7");
        rd(4'hE, "R7");
        tick(7'h30, 7'h15, 6'h01, 6'h31, "R7");
        step(0, 1, 4'hE, 0, 1, 7'h30, 7'h15, 6'h01, 6'h31, "R7");
        rd(4'hE, "R7");
        rd(4'hE, "R7");

        // R5: random mix of accesses and ticks
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [6:0] s, m;
            logic [5:0] h, d;
            op = $urandom_range(0, 9);
            s = ($urandom_range(0, 1) == 1) ? alm_m[0][6:0] : 7'(to_bcd($urandom_range(0, 59)));
            m = ($urandom_range(0, 1) == 1) ? alm_m[1][6:0] : 7'(to_bcd($urandom_range(0, 59)));
            h = ($urandom_range(0, 1) == 1) ? alm_m[2][5:0] : 6'(to_bcd($urandom_range(0, 23)));
            d = ($urandom_range(0, 1) == 1) ? alm_m[3][5:0] : 6'(to_bcd($urandom_range(1, 31)));
            case (op)
                0: wr(4'($urandom_range(8, 11)),
                      ($urandom_range(0, 2) == 0) ? 8'h80 : to_bcd($urandom_range(0, 31)), "R1");
                1: wr(4'hF, 8'($urandom), "R6");
                2, 3: rd(4'hE, "R5");
                4: rd(4'($urandom_range(0, 15)), "R9");
                5: step(0, 1, 4'hE, 0, 1, s, m, h, d, "R7");
                default: tick(s, m, h, d, "R3");
            endcase
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule